// File: doc/BRIEF.md
# One-Shot Instruction Prefix Decoder

This block sits ahead of the main instruction decoder of an 8-bit accumulator processor. It watches the opcode stream for four prefix opcodes. An indirection prefix turns a direct addressing mode into its indirect form. Two swap prefixes exchange the accumulator with the X or the Y register. A stack prefix points the Y-specific data operations at the stack pointer. Prefix effects last for exactly one following instruction. The block then clears its state by itself.

For each instruction, the main decoder supplies the base addressing-mode class and a flag that says whether the instruction already has both direct and indirect zero-page forms. The block returns the effective mode, four register-role selects and a flag that tells the decoder to run the prefix as a one-cycle NOP. It also returns an interrupt hold that keeps interrupts out from the cycle after the first prefix is fetched until the prefixed instruction completes.

A three-state machine drives the prefix state:
- **IDLE**: no prefix is pending. A prefix fetch moves to **GATHER**. Any other fetch stays in IDLE.
- **GATHER**: prefixes are being collected. Each further prefix fetch merges into the pending set and stays in GATHER. The fetch of a non-prefix opcode moves to **APPLY**.
- **APPLY**: the prefixed instruction is executing. Its completion strobe returns to **IDLE** and clears every prefix flag.

Top module: `pfx_decoder`

## Requirements
- R1: After reset, the block is idle. `eff_mode` equals `base_mode`, `nop_sub` and `irq_hold` are 0, and the selects are identity: `acc_sel`=0 (A), `x_sel`=1 (X), `y_sel`=2 (Y), `yidx_sel`=2 (Y). The register codes are 0=A, 1=X, 2=Y, 3=S.
- R2: With the indirection prefix (opcode 0x0B) pending, mode 2 (zp) becomes 8 (zp indirect) and mode 5 (abs) becomes 11 (abs indirect).
- R3: With the indirection prefix pending, the indexed modes convert as follows: 3 (zp,X) becomes 9 ((zp,X)), 4 (zp,Y) becomes 10 ((zp),Y), 6 (abs,X) becomes 12 ((abs,X)) and 7 (abs,Y) becomes 13 ((abs),Y).
- R4: If `both_forms` is 1, the indirection prefix leaves the mode unchanged and `nop_sub` is 1.
- R5: If the indirection prefix is pending and the mode has no indirect form (modes 0, 1 and 8 to 15), the mode passes unchanged and `nop_sub` is 1.
- R6: The A/X swap prefix (0x1B) sets `acc_sel`=X and `x_sel`=A.
- R7: The A/Y swap prefix (0x3B) sets `acc_sel`=Y, `y_sel`=A and `yidx_sel`=A.
- R8: The stack prefix (0x2B) sets `y_sel`=S. `yidx_sel` stays Y, because S is never used as an index register.
- R9: Indirection combines with either swap prefix, and the stack prefix combines with the A/X swap. Each pair gives both effects together.
- R10: In a conflicting pair, the later prefix wins. A/X and A/Y swap cancel each other, and the A/Y swap and the stack prefix cancel each other.
- R11: Prefix effects apply to exactly one instruction. They clear on that instruction's `instr_done`, and a completion strobe seen while still in GATHER is ignored.
- R12: `irq_hold` is 1 from the cycle after a prefix fetch until the cycle after the prefixed instruction's `instr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode fetch strobe |
| opcode | input | 8 | Fetched opcode |
| instr_done | input | 1 | Instruction-complete strobe |
| base_mode | input | 4 | Base addressing-mode class of the current instruction |
| both_forms | input | 1 | The instruction already has direct and indirect zero-page forms |
| eff_mode | output | 4 | Effective addressing mode |
| nop_sub | output | 1 | Run the prefix as a one-cycle NOP |
| acc_sel | output | 2 | Register acting as accumulator |
| x_sel | output | 2 | Register acting as X |
| y_sel | output | 2 | Register for Y-specific data operations |
| yidx_sel | output | 2 | Register used for Y indexing |
| irq_hold | output | 1 | Interrupt inhibit |

## Verification
The prefix flags are registered on the clock edge that accepts a fetch. Every output is combinational from those flags and the live `base_mode`. As a result, the mode, NOP and select results for an instruction appear in the cycle after its prefix fetch edge. `irq_hold` rises one edge after the first prefix fetch and falls one edge after `instr_done`.

The bench drives inputs on falling edges and samples every output on the falling edge that follows the capturing rising edge. Each result is therefore read exactly one register stage after its stimulus.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [3:0] {
        AM_IMP   = 4'd0,  AM_IMM   = 4'd1,  AM_ZP    = 4'd2,  AM_ZPX  = 4'd3,
        AM_ZPY   = 4'd4,  AM_ABS   = 4'd5,  AM_ABSX  = 4'd6,  AM_ABSY = 4'd7,
        AM_ZPI   = 4'd8,  AM_ZPXI  = 4'd9,  AM_ZPIY  = 4'd10, AM_ABSI = 4'd11,
        AM_ABSXI = 4'd12, AM_ABSIY = 4'd13, AM_REL   = 4'd14, AM_STK  = 4'd15
    } amode_t;

    typedef enum logic [1:0] {RS_A = 2'd0, RS_X = 2'd1, RS_Y = 2'd2, RS_S = 2'd3} rsel_t;

    typedef enum logic [1:0] {PT_IDLE = 2'd0, PT_GATHER = 2'd1, PT_APPLY = 2'd2} pstate_t;

    typedef struct packed {
        logic ind;
        logic sax;
        logic say;
        logic osy;
    } pflags_t;

    localparam int NUM_PFX = 4;

    function automatic logic has_indirect(amode_t m);
        return (m inside {AM_ZP, AM_ZPX, AM_ZPY, AM_ABS, AM_ABSX, AM_ABSY});
    endfunction

    function automatic amode_t to_indirect(amode_t m);
        amode_t r;
        unique case (m)
            AM_ZP:   r = AM_ZPI;
            AM_ZPX:  r = AM_ZPXI;
            AM_ZPY:  r = AM_ZPIY;
            AM_ABS:  r = AM_ABSI;
            AM_ABSX: r = AM_ABSXI;
            AM_ABSY: r = AM_ABSIY;
            default: r = m;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pfx_track.sv
module pfx_track
    import pfx_pkg::*;
#(
    parameter int             OPC_W = 8,
    parameter logic [OPC_W-1:0] P_IND = 8'h0B,
    parameter logic [OPC_W-1:0] P_SAX = 8'h1B,
    parameter logic [OPC_W-1:0] P_SAY = 8'h3B,
    parameter logic [OPC_W-1:0] P_OSY = 8'h2B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic             instr_done,
    output pstate_t          state,
    output pflags_t          flags
);

    localparam logic [OPC_W-1:0] CODES [NUM_PFX] = '{P_IND, P_SAX, P_SAY, P_OSY};

    logic [NUM_PFX-1:0] hit;
    logic               is_pfx;
    pstate_t            nxt_state;
    pflags_t            nxt_flags;

    for (genvar g = 0; g < NUM_PFX; g++) begin : g_hit
        assign hit[g] = (opcode == CODES[g]);
    end
    assign is_pfx = |hit;

    // later prefix wins over a conflicting earlier one
    function automatic pflags_t merge(pflags_t f, logic [NUM_PFX-1:0] h);
        pflags_t r = f;
        if (h[0]) r.ind = 1'b1;
        if (h[1]) begin r.sax = 1'b1; r.say = 1'b0; end
        if (h[2]) begin r.say = 1'b1; r.sax = 1'b0; r.osy = 1'b0; end
        if (h[3]) begin r.osy = 1'b1; r.say = 1'b0; end
        return r;
    endfunction

    always_comb begin
        nxt_state = state;
        nxt_flags = flags;
        unique case (state)
            PT_IDLE: begin
                if (op_valid && is_pfx) begin
                    nxt_state = PT_GATHER;
                    nxt_flags = merge('0, hit);
                end
            end
            PT_GATHER: begin
                if (op_valid) begin
                    if (is_pfx) nxt_flags = merge(flags, hit);
                    else        nxt_state = PT_APPLY;
                end
            end
            PT_APPLY: begin
                if (instr_done) begin
                    nxt_state = PT_IDLE;
                    nxt_flags = '0;
                end
            end
            default: begin
                nxt_state = PT_IDLE;
                nxt_flags = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PT_IDLE;
            flags <= '0;
        end else begin
            state <= nxt_state;
            flags <= nxt_flags;
        end
    end

    a_r10_no_dual_swap: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.sax && flags.say));
    a_r10_no_osy_with_say: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags.osy && flags.say));
    a_r11_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PT_APPLY && instr_done) |=> (state == PT_IDLE && flags == '0));
    a_r11_hold_in_apply: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PT_APPLY && !instr_done) |=> (state == PT_APPLY && $stable(flags)));
    a_r12_prefix_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_pfx && state != PT_APPLY) |=> (state != PT_IDLE));

endmodule

// File: rtl/pfx_mode_xlat.sv
module pfx_mode_xlat
    import pfx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   active,
    input  logic   ind,
    input  logic   both_forms,
    input  amode_t base_mode,
    output amode_t eff_mode,
    output logic   nop_sub
);

    logic convertible;
    logic apply_ind;

    assign convertible = has_indirect(base_mode) && !both_forms;
    assign apply_ind   = active && ind;

    always_comb begin
        eff_mode = base_mode;
        nop_sub  = 1'b0;
        if (apply_ind) begin
            if (convertible) eff_mode = to_indirect(base_mode);
            else             nop_sub  = 1'b1;
        end
    end

    a_r4_both_forms_pass: assert property (@(posedge clk) disable iff (!rst_n)
        both_forms |-> (eff_mode == base_mode));
    a_r5_nop_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        nop_sub |-> (eff_mode == base_mode && active));

endmodule

// File: rtl/pfx_remap.sv
module pfx_remap
    import pfx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  sax,
    input  logic  say,
    input  logic  osy,
    output rsel_t acc_sel,
    output rsel_t x_sel,
    output rsel_t y_sel,
    output rsel_t yidx_sel
);

    always_comb begin
        acc_sel  = RS_A;
        x_sel    = RS_X;
        y_sel    = RS_Y;
        yidx_sel = RS_Y;
        if (active) begin
            if (sax) begin
                acc_sel = RS_X;
                x_sel   = RS_A;
            end
            if (say) begin
                acc_sel  = RS_Y;
                y_sel    = RS_A;
                yidx_sel = RS_A;
            end
            if (osy) y_sel = RS_S;
        end
    end

    a_r8_idx_never_s: assert property (@(posedge clk) disable iff (!rst_n)
        yidx_sel != RS_S);
    a_r1_idle_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (acc_sel == RS_A && x_sel == RS_X && y_sel == RS_Y));

endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder
    import pfx_pkg::*;
#(
    parameter int             OPC_W = 8,
    parameter logic [OPC_W-1:0] P_IND = 8'h0B,
    parameter logic [OPC_W-1:0] P_SAX = 8'h1B,
    parameter logic [OPC_W-1:0] P_SAY = 8'h3B,
    parameter logic [OPC_W-1:0] P_OSY = 8'h2B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic             instr_done,
    input  logic [3:0]       base_mode,
    input  logic             both_forms,
    output logic [3:0]       eff_mode,
    output logic             nop_sub,
    output logic [1:0]       acc_sel,
    output logic [1:0]       x_sel,
    output logic [1:0]       y_sel,
    output logic [1:0]       yidx_sel,
    output logic             irq_hold
);

    pstate_t state;
    pflags_t flags;
    logic    active;
    amode_t  mode_t_out;
    rsel_t   acc_r, x_r, y_r, yi_r;

    pfx_track #(
        .OPC_W(OPC_W), .P_IND(P_IND), .P_SAX(P_SAX), .P_SAY(P_SAY), .P_OSY(P_OSY)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .instr_done(instr_done), .state(state), .flags(flags)
    );

    assign active = (state != PT_IDLE);

    pfx_mode_xlat u_xlat (
        .clk(clk), .rst_n(rst_n), .active(active), .ind(flags.ind),
        .both_forms(both_forms), .base_mode(amode_t'(base_mode)),
        .eff_mode(mode_t_out), .nop_sub(nop_sub)
    );

    pfx_remap u_remap (
        .clk(clk), .rst_n(rst_n), .active(active), .sax(flags.sax),
        .say(flags.say), .osy(flags.osy), .acc_sel(acc_r), .x_sel(x_r),
        .y_sel(y_r), .yidx_sel(yi_r)
    );

    assign eff_mode = mode_t_out;
    assign acc_sel  = acc_r;
    assign x_sel    = x_r;
    assign y_sel    = y_r;
    assign yidx_sel = yi_r;
    assign irq_hold = active;

    a_r12_hold_drops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PT_APPLY && instr_done) |=> !irq_hold);

endmodule

// File: tb/sim_pfx_decoder.sv
module sim_pfx_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic       instr_done = 1'b0;
    logic [3:0] base_mode = 4'd0;
    logic       both_forms = 1'b0;
    logic [3:0] eff_mode;
    logic       nop_sub;
    logic [1:0] acc_sel, x_sel, y_sel, yidx_sel;
    logic       irq_hold;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pfx_decoder u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .instr_done(instr_done), .base_mode(base_mode), .both_forms(both_forms),
        .eff_mode(eff_mode), .nop_sub(nop_sub), .acc_sel(acc_sel), .x_sel(x_sel),
        .y_sel(y_sel), .yidx_sel(yidx_sel), .irq_hold(irq_hold)
    );

    localparam logic [7:0] C_IND = 8'h0B, C_SAX = 8'h1B, C_SAY = 8'h3B, C_OSY = 8'h2B;
    localparam logic [7:0] C_NONE = 8'h00, C_INSN = 8'hA5;

    typedef struct packed {
        logic [7:0] p1;
        logic [7:0] p2;
        logic [3:0] mode;
        logic       both;
        logic [3:0] emode;
        logic       enop;
        logic [1:0] eacc;
        logic [1:0] ex;
        logic [1:0] ey;
        logic [1:0] eyi;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{C_IND,  C_NONE, 4'd2, 1'b0, 4'd8,  1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd2},  // R2
        '{C_IND,  C_NONE, 4'd5, 1'b0, 4'd11, 1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd2},  // R2
        '{C_IND,  C_NONE, 4'd3, 1'b0, 4'd9,  1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd3},  // R3
        '{C_IND,  C_NONE, 4'd4, 1'b0, 4'd10, 1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd3},  // R3
        '{C_IND,  C_NONE, 4'd6, 1'b0, 4'd12, 1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd3},  // R3
        '{C_IND,  C_NONE, 4'd7, 1'b0, 4'd13, 1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd3},  // R3
        '{C_IND,  C_NONE, 4'd2, 1'b1, 4'd2,  1'b1, 2'd0, 2'd1, 2'd2, 2'd2, 4'd4},  // R4
        '{C_IND,  C_NONE, 4'd1, 1'b0, 4'd1,  1'b1, 2'd0, 2'd1, 2'd2, 2'd2, 4'd5},  // R5
        '{C_SAX,  C_NONE, 4'd1, 1'b0, 4'd1,  1'b0, 2'd1, 2'd0, 2'd2, 2'd2, 4'd6},  // R6
        '{C_SAY,  C_NONE, 4'd4, 1'b0, 4'd4,  1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 4'd7},  // R7
        '{C_OSY,  C_NONE, 4'd7, 1'b0, 4'd7,  1'b0, 2'd0, 2'd1, 2'd3, 2'd2, 4'd8},  // R8
        '{C_IND,  C_SAX,  4'd7, 1'b0, 4'd13, 1'b0, 2'd1, 2'd0, 2'd2, 2'd2, 4'd9},  // R9
        '{C_OSY,  C_SAX,  4'd0, 1'b0, 4'd0,  1'b0, 2'd1, 2'd0, 2'd3, 2'd2, 4'd9},  // R9
        '{C_SAY,  C_SAX,  4'd2, 1'b0, 4'd2,  1'b0, 2'd1, 2'd0, 2'd2, 2'd2, 4'd10}, // R10
        '{C_SAX,  C_SAY,  4'd2, 1'b0, 4'd2,  1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 4'd10}, // R10
        '{C_OSY,  C_SAY,  4'd2, 1'b0, 4'd2,  1'b0, 2'd2, 2'd1, 2'd0, 2'd0, 4'd10}, // R10
        '{C_SAY,  C_OSY,  4'd2, 1'b0, 4'd2,  1'b0, 2'd0, 2'd1, 2'd3, 2'd2, 4'd10}, // R10
        '{C_NONE, C_NONE, 4'd2, 1'b0, 4'd2,  1'b0, 2'd0, 2'd1, 2'd2, 2'd2, 4'd11}  // R11
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic fetch(input logic [7:0] opc);
        @(negedge clk);
        op_valid = 1'b1;
        opcode   = opc;
        @(negedge clk);
        op_valid = 1'b0;
        opcode   = 8'h00;
    endtask

    task automatic finish_insn();
        @(negedge clk);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic check_identity(input string tag);
        chk({tag, " acc"},  int'(acc_sel),  0);
        chk({tag, " x"},    int'(x_sel),    1);
        chk({tag, " y"},    int'(y_sel),    2);
        chk({tag, " yidx"}, int'(yidx_sel), 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        base_mode = 4'd2;
        // R1: reset state
        @(negedge clk);
        chk("R1 irq_hold", int'(irq_hold), 0);
        chk("R1 nop", int'(nop_sub), 0);
        chk("R1 mode", int'(eff_mode), 2);
        check_identity("R1");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("R%0d v%0d", VECS[i].req, i);
            base_mode  = VECS[i].mode;
            both_forms = VECS[i].both;
            if (VECS[i].p1 != C_NONE) fetch(VECS[i].p1);
            if (VECS[i].p2 != C_NONE) fetch(VECS[i].p2);
            // R12: held once any prefix is pending
            if (VECS[i].p1 != C_NONE) chk({t, " R12 hold"}, int'(irq_hold), 1);
            fetch(C_INSN);
            chk({t, " mode"}, int'(eff_mode), int'(VECS[i].emode));
            chk({t, " nop"},  int'(nop_sub),  int'(VECS[i].enop));
            chk({t, " acc"},  int'(acc_sel),  int'(VECS[i].eacc));
            chk({t, " x"},    int'(x_sel),    int'(VECS[i].ex));
            chk({t, " y"},    int'(y_sel),    int'(VECS[i].ey));
            chk({t, " yidx"}, int'(yidx_sel), int'(VECS[i].eyi));
            finish_insn();
            // R11: cleared after the one instruction
            chk({t, " R11 mode clr"}, int'(eff_mode), int'(VECS[i].mode));
            chk({t, " R12 released"}, int'(irq_hold), 0);
            check_identity({t, " R11 clr"});
        end
        both_forms = 1'b0;

        // R11: completion strobe during GATHER ignored
        base_mode = 4'd2;
        fetch(C_IND);
        finish_insn();
        chk("R11 done in gather keeps hold", int'(irq_hold), 1);
        fetch(C_INSN);
        chk("R11 prefix survives early done", int'(eff_mode), 8);
        // R12: held across a long instruction
        repeat (3) @(negedge clk);
        chk("R12 hold in long insn", int'(irq_hold), 1);
        finish_insn();
        chk("R12 drop after done", int'(irq_hold), 0);
        // R11: next instruction is unprefixed
        fetch(C_INSN);
        chk("R11 next insn plain", int'(eff_mode), 2);
        chk("R11 next insn no hold", int'(irq_hold), 0);
        finish_insn();

        // R1: reset in the middle of a prefix
        fetch(C_SAX);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears hold", int'(irq_hold), 0);
        chk("R1 reset clears acc", int'(acc_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule